// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block sends frames that software has queued in a ring of transmit descriptors. Each descriptor is a 32-bit control word plus a buffer pointer, and the descriptors sit in a small memory inside the block. Software fills in a descriptor through a write port and hands it to the engine by setting the ownership bit. It then pulses the poll-demand input. The engine checks the descriptor at its current ring index. If the engine owns that descriptor, it reads the frame bytes from an external buffer through an address/data port with combinational read. It sends those bytes out one per cycle, with first-byte and last-byte markers. When the frame is done, it clears the ownership bit in the stored control word, pulses a done flag and moves to the next descriptor.

The engine keeps walking the ring without another poll until it reaches a descriptor that software still owns. It then goes idle and keeps its index, so the next poll looks at that same descriptor again. The ring length is not programmed. A marker bit in the last descriptor's control word sends the index back to zero. When no marker is set, the index wraps after the last memory entry. Short frames are padded with zero bytes. A descriptor with a zero or oversized length, or with an odd buffer pointer, is not sent. It is flagged as an error and returned to software.

Top module: `txring_engine`

## Requirements
- R1: After reset the engine is idle, no output strobe is active, the ring index is 0 and every stored control word reads 0.
- R2: A poll-demand pulse makes the engine examine the descriptor at its current index. If the ownership bit (bit 31) is 1, the engine emits the bytes read from buffer addresses pointer+0, pointer+1, … in order, one per cycle while txValid is high.
- R3: If the examined descriptor has ownership bit 0, the engine emits nothing, does not advance its index, and stays idle until the next poll-demand pulse.
- R4: When a descriptor has been sent, its stored control word reads back with bit 31 cleared and all other bits unchanged, and txDone pulses for exactly one cycle per sent descriptor.
- R5: After finishing a descriptor, the engine goes on to the next index without a new poll, and keeps going until it finds a software-owned descriptor.
- R6: A descriptor with the end-of-ring bit (bit 30) set is followed by index 0. Index DEPTH-1 is also followed by index 0.
- R7: txFirst is high on the first byte of a descriptor only when its first-segment bit (bit 28) is 1. txLast is high on its final byte only when its last-segment bit (bit 29) is 1.
- R8: The length field is bits [10:0]. A length below 60 is sent as 60 bytes, and bytes past the programmed length are 0.
- R9: A descriptor whose length is 0 or above 1536, or whose pointer is odd, emits no bytes. It pulses txErr (not txDone), has bit 31 cleared and is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollWr | input | 1 | Poll-demand write strobe |
| descWrEn | input | 1 | Descriptor write enable |
| descWrIdx | input | 3 | Descriptor index to write |
| descWrCtrl | input | 32 | Control word to store |
| descWrPtr | input | 16 | Buffer pointer to store |
| descRdIdx | input | 3 | Descriptor index to read back |
| descRdCtrl | output | 32 | Stored control word at descRdIdx |
| bufAddr | output | 16 | Buffer byte address |
| bufData | input | 8 | Buffer byte at bufAddr (same cycle) |
| txValid | output | 1 | Output byte valid |
| txData | output | 8 | Output byte |
| txFirst | output | 1 | First byte of a first-segment descriptor |
| txLast | output | 1 | Final byte of a last-segment descriptor |
| txDone | output | 1 | One-cycle pulse per descriptor sent |
| txErr | output | 1 | One-cycle pulse per descriptor rejected |

## Verification
The hardest state to reach from the ports is an engine that stops partway around the ring and later resumes from that same index. Reaching it requires a poll that lands on a software-owned descriptor, followed by more descriptors queued at positions that depend on where earlier rounds stopped. The stimulus handles this with a bench model that follows the ring index across many random rounds. Each round grants a random number of descriptors starting at the model's index, mixes in invalid ones, and sometimes grants none. Directed cases cover padding, the marker combinations, wrapping with and without the end-of-ring bit, and a poll on a descriptor that software still owns.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int CTRL_W  = 32;
  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 30;
  localparam int LS_BIT  = 29;
  localparam int FS_BIT  = 28;

  typedef struct packed {
    logic loadDesc;
    logic sendByte;
    logic writeBack;
    logic advance;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SEND  = 2'd2,
    ST_WBACK = 2'd3
  } engState_t;
endpackage

// File: rtl/txring_datapath.sv
module txring_datapath
  import txring_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 1536,
  parameter int MIN_LEN = 60,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              descWrEn,
  input  logic [IDX_W-1:0]  descWrIdx,
  input  logic [CTRL_W-1:0] descWrCtrl,
  input  logic [ADDR_W-1:0] descWrPtr,
  input  logic [IDX_W-1:0]  descRdIdx,
  output logic [CTRL_W-1:0] descRdCtrl,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        bufData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txFirst,
  output logic              txLast,
  output logic              descOwned,
  output logic              descBad,
  output logic              lastByte
);
  logic [CTRL_W-1:0] ctrlMem [DEPTH];
  logic [ADDR_W-1:0] ptrMem  [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  curLen, byteCnt, effLen, lookLen;
  logic [ADDR_W-1:0] curPtr;
  logic              curFs, curLs, lookEor;

  assign lookLen   = ctrlMem[idx][LEN_W-1:0];
  assign lookEor   = ctrlMem[idx][EOR_BIT];
  assign descOwned = ctrlMem[idx][OWN_BIT];
  assign descBad   = (lookLen == '0) || (int'(lookLen) > MAX_LEN) || ptrMem[idx][0];

  assign effLen   = (int'(curLen) < MIN_LEN) ? LEN_W'(MIN_LEN) : curLen;
  assign lastByte = (byteCnt == effLen - LEN_W'(1));

  // descriptor storage: engine write-back first, software write wins on collision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        ctrlMem[i] <= '0;
        ptrMem[i]  <= '0;
      end
    end else begin
      if (strb.writeBack) ctrlMem[idx][OWN_BIT] <= 1'b0;
      if (descWrEn) begin
        ctrlMem[descWrIdx] <= descWrCtrl;
        ptrMem[descWrIdx]  <= descWrPtr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= '0;
      curLen  <= '0;
      curPtr  <= '0;
      curFs   <= 1'b0;
      curLs   <= 1'b0;
      byteCnt <= '0;
    end else begin
      if (strb.loadDesc) begin
        curLen  <= lookLen;
        curPtr  <= ptrMem[idx];
        curFs   <= ctrlMem[idx][FS_BIT];
        curLs   <= ctrlMem[idx][LS_BIT];
        byteCnt <= '0;
      end else if (strb.sendByte) begin
        byteCnt <= byteCnt + LEN_W'(1);
      end
      if (strb.advance)
        idx <= (lookEor || (int'(idx) == DEPTH - 1)) ? '0 : idx + IDX_W'(1);
    end
  end

  assign descRdCtrl = ctrlMem[descRdIdx];
  assign bufAddr    = curPtr + ADDR_W'(byteCnt);
  assign txValid    = strb.sendByte;
  assign txData     = (byteCnt < curLen) ? bufData : 8'h00;
  assign txFirst    = strb.sendByte && (byteCnt == '0) && curFs;
  assign txLast     = strb.sendByte && lastByte && curLs;

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.advance) |-> $stable(idx));
  // R6
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.advance && lookEor) |-> (idx == '0));
  // R7
  marker_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txFirst || txLast) |-> txValid);
  // R4
  owner_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.writeBack) && !$past(descWrEn)) |-> !ctrlMem[$past(idx)][OWN_BIT]);
endmodule

// File: rtl/txring_control.sv
module txring_control
  import txring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pollWr,
  input  logic        descOwned,
  input  logic        descBad,
  input  logic        lastByte,
  output ctlStrobes_t strb,
  output logic        txDone,
  output logic        txErr
);
  engState_t state, stateNext;
  logic      pollPend, errQ;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE:  if (pollPend) stateNext = ST_CHECK;
      ST_CHECK: begin
        if (!descOwned)   stateNext = ST_IDLE;
        else if (descBad) stateNext = ST_WBACK;
        else begin
          strb.loadDesc = 1'b1;
          stateNext     = ST_SEND;
        end
      end
      ST_SEND: begin
        strb.sendByte = 1'b1;
        if (lastByte) stateNext = ST_WBACK;
      end
      ST_WBACK: begin
        strb.writeBack = 1'b1;
        strb.advance   = 1'b1;
        stateNext      = ST_CHECK;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pollPend <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      state    <= stateNext;
      pollPend <= pollWr || (pollPend && state != ST_IDLE);
      if (state == ST_CHECK) errQ <= descBad;
    end
  end

  assign txDone = (state == ST_WBACK) && !errQ;
  assign txErr  = (state == ST_WBACK) && errQ;

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txDone && txErr));
  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sendByte && lastByte) |=> txDone);
  // R3
  idle_unowned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !descOwned) |=> (state == ST_IDLE));
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 1536,
  parameter int MIN_LEN = 60,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pollWr,
  input  logic              descWrEn,
  input  logic [IDX_W-1:0]  descWrIdx,
  input  logic [31:0]       descWrCtrl,
  input  logic [ADDR_W-1:0] descWrPtr,
  input  logic [IDX_W-1:0]  descRdIdx,
  output logic [31:0]       descRdCtrl,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        bufData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txFirst,
  output logic              txLast,
  output logic              txDone,
  output logic              txErr
);
  ctlStrobes_t strb;
  logic descOwned, descBad, lastByte;

  txring_control u_ctl (
    .clk, .rstN, .pollWr, .descOwned, .descBad, .lastByte,
    .strb, .txDone, .txErr
  );

  txring_datapath #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)
  ) u_dp (
    .clk, .rstN, .strb, .descWrEn, .descWrIdx, .descWrCtrl, .descWrPtr,
    .descRdIdx, .descRdCtrl, .bufAddr, .bufData, .txValid, .txData,
    .txFirst, .txLast, .descOwned, .descBad, .lastByte
  );
endmodule

// File: tb/txring_engine_test.sv
`timescale 1ns/1ps
module txring_engine_test;
  localparam int DEPTH = 8;
  logic clk = 0, rstN = 0, pollWr = 0, descWrEn = 0;
  logic [2:0] descWrIdx = 0, descRdIdx = 0;
  logic [31:0] descWrCtrl = 0, descRdCtrl;
  logic [15:0] descWrPtr = 0, bufAddr;
  logic [7:0] bufData, txData;
  logic txValid, txFirst, txLast, txDone, txErr;

  int checks = 0, errors = 0;
  logic [31:0] mCtrl [DEPTH];
  logic [15:0] mPtr  [DEPTH];
  int mIdx = 0;
  logic [7:0] expData [8192];
  logic expFirst [8192], expLast [8192];
  int expN, gotN, expDone, gotDone, expErr, gotErr, bound;
  string curReq = "R2";

  always #2 clk = ~clk;

  function automatic logic [7:0] bufByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign bufData = bufByte(bufAddr);

  txring_engine uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    if (txValid) begin
      if (gotN < expN)
        chk(txData == expData[gotN] && txFirst == expFirst[gotN] && txLast == expLast[gotN],
            curReq, {txData, txFirst, txLast}, {expData[gotN], expFirst[gotN], expLast[gotN]});
      gotN++;
    end
    if (txDone) gotDone++;
    if (txErr)  gotErr++;
  end

  task automatic writeDesc(input int i, input logic [31:0] c, input logic [15:0] p);
    @(negedge clk);
    descWrEn = 1; descWrIdx = 3'(i); descWrCtrl = c; descWrPtr = p;
    @(negedge clk);
    descWrEn = 0;
    mCtrl[i] = c; mPtr[i] = p;
  endtask

  function automatic logic [31:0] mk(bit own, bit eor, bit ls, bit fs, int len);
    return {own, eor, ls, fs, 17'd0, 11'(len)};
  endfunction

  task automatic runModel();
    expN = 0; gotN = 0; expDone = 0; gotDone = 0; expErr = 0; gotErr = 0; bound = 20;
    for (int n = 0; n < DEPTH + 1; n++) begin
      logic [31:0] c = mCtrl[mIdx];
      int len = int'(c[10:0]);
      if (!c[31]) break;
      if (len == 0 || len > 1536 || mPtr[mIdx][0]) expErr++;
      else begin
        int eff = (len < 60) ? 60 : len;
        for (int b = 0; b < eff; b++) begin
          expData[expN]  = (b < len) ? bufByte(mPtr[mIdx] + 16'(b)) : 8'h00;
          expFirst[expN] = (b == 0) && c[28];
          expLast[expN]  = (b == eff - 1) && c[29];
          expN++;
        end
        expDone++;
        bound += eff;
      end
      bound += 3;
      mCtrl[mIdx][31] = 1'b0;
      mIdx = (c[30] || mIdx == DEPTH - 1) ? 0 : mIdx + 1;
    end
  endtask

  task automatic runAndCheck(input string req);
    curReq = req;
    runModel();
    @(negedge clk); pollWr = 1;
    @(negedge clk); pollWr = 0;
    repeat (bound) @(negedge clk);
    chk(gotN == expN, {req, " byte count"}, gotN, expN);
    chk(gotDone == expDone, "R4 done pulses", gotDone, expDone);
    chk(gotErr == expErr, "R9 error pulses", gotErr, expErr);
    for (int i = 0; i < DEPTH; i++) begin
      descRdIdx = 3'(i); #0.1;
      chk(descRdCtrl == mCtrl[i], "R4 readback", descRdCtrl, mCtrl[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0DE));
    for (int i = 0; i < DEPTH; i++) begin mCtrl[i] = 0; mPtr[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(!txValid && !txDone && !txErr, "R1 idle outputs", txValid, 0);
    for (int i = 0; i < DEPTH; i++) begin
      descRdIdx = 3'(i); #0.1;
      chk(descRdCtrl == 0, "R1 ctrl cleared", descRdCtrl, 0);
    end
    // R3 software-owned descriptor: nothing happens, index stays 0
    writeDesc(0, mk(0, 0, 1, 1, 100), 16'h0100);
    runAndCheck("R3");
    // R2 R3: same index serviced once granted, ring of 5 marked at 4
    writeDesc(4, mk(0, 1, 1, 1, 80), 16'h0400);
    writeDesc(0, mk(1, 0, 1, 1, 100), 16'h0100);
    runAndCheck("R2");
    // R8 padding, R7 marker combinations, R5 continuous walk
    writeDesc(1, mk(1, 0, 1, 1, 10), 16'h1000);
    writeDesc(2, mk(1, 0, 0, 1, 64), 16'h2002);
    writeDesc(3, mk(1, 0, 1, 0, 1), 16'h3000);
    runAndCheck("R8");
    // R9 invalid descriptors mixed with a good one, R6 marker wrap
    writeDesc(4, mk(1, 1, 1, 1, 0), 16'h4000);
    writeDesc(0, mk(1, 0, 1, 1, 70), 16'h5001);
    writeDesc(1, mk(1, 0, 1, 1, 1537), 16'h6000);
    writeDesc(2, mk(1, 0, 1, 1, 1536), 16'h7000);
    runAndCheck("R9");
    // R6 wrap after the last entry with no marker
    for (int i = 0; i < DEPTH; i++) writeDesc(i, mk(1, 0, 1, 1, 20 + i), 16'(i * 256));
    runAndCheck("R6");
    // random rounds, R5
    for (int r = 0; r < 25; r++) begin
      int k = $urandom % 7;
      for (int i = 0; i < DEPTH; i++) begin
        int sel = $urandom % 10;
        int len = (sel == 0) ? 0 : 1 + ($urandom % 150);
        logic [15:0] p = 16'($urandom) & 16'hFFFE;
        if (sel == 1) p[0] = 1'b1;
        writeDesc(i, mk(0, i == 4, $urandom % 2, $urandom % 2, len), p);
      end
      begin
        int j = mIdx;
        for (int s = 0; s < k; s++) begin
          writeDesc(j, mCtrl[j] | 32'h8000_0000, mPtr[j]);
          j = (mCtrl[j][30] || j == DEPTH - 1) ? 0 : j + 1;
        end
      end
      runAndCheck("R5");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule